// File: doc/BRIEF.md
# SCL High-Count Register with Bus-Idle Detector

This block holds the 16-bit count that sets how long SCL stays high in standard-speed operation of an I2C controller. Software programs it through an APB-style register port, which can be built 32 bits wide or 8 bits wide. The block keeps the stored count legal: it refuses writes while the controller is running, and it raises any value below six to six. On the narrow bus, a full count takes two byte writes, low byte first. The stored value drives the SCL waveform generator, which sits outside this block.

The same count sets the bus-idle threshold. A 16-bit counter runs while the controller is enabled and both SCL and SDA sample high. When the counter reaches the programmed count plus ten, the block raises a bus-idle flag and holds it until a low level shows up. A build parameter can instead fix the count at its reset value, so that the register ignores all writes.

Top module: `scl_hcnt_regblk`

## Requirements
- R1: After reset the stored count equals the RESET_HCNT parameter (default 500) and bus_idle is 0.
- R2: With DATA_W=32, a completed APB write (psel, penable and pwrite high on one clock edge) to address BASE stores pwdata[15:0] while ctrl_enable is 0. The new count appears on hcnt_out and prdata after that edge. prdata[31:15+1] always reads 0.
- R3: Any write, including a low-byte write on the 8-bit bus, that completes while ctrl_enable is 1 leaves the stored count and the byte shadow unchanged.
- R4: A write of a value from 0 to 5 stores 6. Values of 6 and above are stored unchanged.
- R5: With DATA_W=8, a write to BASE puts the byte into a shadow and leaves the count unchanged. A later write to BASE+1 stores {high byte, shadow}, clamped as in R4. Reads at BASE and BASE+1 return the low and high byte of the stored count.
- R6: With HARD_CODED=1, every write is ignored, and both hcnt_out and prdata always carry RESET_HCNT.
- R7: While ctrl_enable, scl_in and sda_in are all 1, the idle counter advances once per clock. bus_idle rises after exactly count+10 such consecutive clock edges.
- R8: bus_idle stays 1 while the lines remain high. It reads 0 one clock after a 0 is sampled on scl_in or sda_in, or after ctrl_enable is sampled 0.
- R9: The idle threshold follows the stored count of each instance. Different counts give different rise times.
- R10: On the 32-bit bus, writes to any address other than BASE are ignored, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | Read data, decoded from paddr |
| ctrl_enable | input | 1 | Controller enable bit; 1 blocks writes |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| hcnt_out | output | 16 | Effective SCL high count |
| bus_idle | output | 1 | Bus-idle flag |

## Verification
If the stored count were corrupted, the error would show on hcnt_out and prdata on the next sampled cycle. A wrong shadow byte would stay hidden until the following high-byte commit, so the bench commits right after each low-byte write and checks the value. A fault in the idle counter or the threshold shows only as bus_idle rising one or more cycles off from count+10. For this reason the bench samples the edges on both sides of the expected rise, for two different counts.

// File: rtl/hcnt_pkg.sv
package hcnt_pkg;

    localparam int HCNT_W      = 16;
    localparam int MIN_HCNT    = 6;
    localparam int IDLE_MARGIN = 10;

    typedef logic [HCNT_W-1:0] hcnt_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_FULL,
        WR_LO,
        WR_HI
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e kind;
        hcnt_t    data;
    } wr_req_t;

    function automatic hcnt_t clamp_hcnt(input hcnt_t v);
        return (v < hcnt_t'(MIN_HCNT)) ? hcnt_t'(MIN_HCNT) : v;
    endfunction

    function automatic hcnt_t idle_limit(input hcnt_t v);
        logic [HCNT_W:0] s;
        s = {1'b0, v} + (HCNT_W+1)'(IDLE_MARGIN);
        return s[HCNT_W] ? {HCNT_W{1'b1}} : s[HCNT_W-1:0];
    endfunction

endpackage

// File: rtl/hcnt_bus_if.sv
module hcnt_bus_if
    import hcnt_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h20
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  hcnt_t             cnt,
    output wr_req_t           req,
    output logic [DATA_W-1:0] prdata
);

    localparam logic [ADDR_W-1:0] HI_ADDR = BASE + ADDR_W'(1);

    logic wr_stb;
    assign wr_stb = psel & penable & pwrite;

    generate
        if (DATA_W == 8) begin : g_narrow
            always_comb begin
                req = '{kind: WR_NONE, data: '0};
                if (wr_stb && paddr == BASE)
                    req = '{kind: WR_LO, data: {8'h00, pwdata}};
                else if (wr_stb && paddr == HI_ADDR)
                    req = '{kind: WR_HI, data: {8'h00, pwdata}};
            end
            always_comb begin
                prdata = '0;
                if (paddr == BASE)         prdata = cnt[7:0];
                else if (paddr == HI_ADDR) prdata = cnt[15:8];
            end
        end else begin : g_wide
            logic unused_rsvd;
            assign unused_rsvd = ^pwdata[DATA_W-1:HCNT_W];
            always_comb begin
                req = '{kind: WR_NONE, data: '0};
                if (wr_stb && paddr == BASE)
                    req = '{kind: WR_FULL, data: pwdata[HCNT_W-1:0]};
            end
            always_comb begin
                prdata = '0;
                if (paddr == BASE) prdata[HCNT_W-1:0] = cnt;
            end
        end
    endgenerate

endmodule

// File: rtl/hcnt_store.sv
module hcnt_store
    import hcnt_pkg::*;
#(
    parameter hcnt_t RESET_HCNT = 16'd500,
    parameter bit    HARD_CODED = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ctrl_enable,
    input  wr_req_t req,
    output hcnt_t   cnt
);

    localparam hcnt_t RST_VAL = clamp_hcnt(RESET_HCNT);

    generate
        if (HARD_CODED) begin : g_fixed
            logic unused_in;
            assign unused_in = ^{req, ctrl_enable, clk, rst};
            assign cnt = RST_VAL;
        end else begin : g_prog
            hcnt_t      cnt_q;
            logic [7:0] lo_shadow_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q       <= RST_VAL;
                    lo_shadow_q <= '0;
                end else if (!ctrl_enable) begin
                    unique case (req.kind)
                        WR_FULL: cnt_q       <= clamp_hcnt(req.data);
                        WR_LO:   lo_shadow_q <= req.data[7:0];
                        WR_HI:   cnt_q       <= clamp_hcnt({req.data[7:0], lo_shadow_q});
                        default: ;
                    endcase
                end
            end

            assign cnt = cnt_q;

            // R3: running controller freezes the count
            p_en_blocks_r3: assert property (@(posedge clk) disable iff (rst)
                ctrl_enable |=> $stable(cnt_q));
            // R4: stored count never below the floor
            p_floor_r4: assert property (@(posedge clk) disable iff (rst)
                cnt_q >= hcnt_t'(MIN_HCNT));
            // R5: low-byte write only fills the shadow
            p_lo_shadow_r5: assert property (@(posedge clk) disable iff (rst)
                (req.kind == WR_LO) |=> $stable(cnt_q));
        end
    endgenerate

endmodule

// File: rtl/hcnt_idle_det.sv
module hcnt_idle_det
    import hcnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctrl_enable,
    input  logic  scl_in,
    input  logic  sda_in,
    input  hcnt_t cnt,
    output logic  bus_idle
);

    hcnt_t thr;
    hcnt_t idle_q;
    logic  lines_hi;

    assign thr      = idle_limit(cnt);
    assign lines_hi = ctrl_enable & scl_in & sda_in;

    always_ff @(posedge clk) begin
        if (rst || !lines_hi)
            idle_q <= '0;
        else if (idle_q < thr)
            idle_q <= idle_q + hcnt_t'(1);
    end

    assign bus_idle = (idle_q >= thr);

    // R8: any low sample clears the flag on the next cycle
    p_low_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !lines_hi |=> !bus_idle);
    // R7: flag rises only after a high sample
    p_rise_high_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_idle) |-> $past(lines_hi));
    // R7: counter saturates at its threshold
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        idle_q <= thr);

endmodule

// File: rtl/scl_hcnt_regblk.sv
module scl_hcnt_regblk
    import hcnt_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BASE       = 8'h20,
    parameter logic [15:0]       RESET_HCNT = 16'd500,
    parameter bit                HARD_CODED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              ctrl_enable,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic [15:0]       hcnt_out,
    output logic              bus_idle
);

    wr_req_t req;
    hcnt_t   cnt;

    hcnt_bus_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_bus (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .cnt     (cnt),
        .req     (req),
        .prdata  (prdata)
    );

    hcnt_store #(.RESET_HCNT(RESET_HCNT), .HARD_CODED(HARD_CODED)) u_store (
        .clk         (clk),
        .rst         (rst),
        .ctrl_enable (ctrl_enable),
        .req         (req),
        .cnt         (cnt)
    );

    hcnt_idle_det u_idle (
        .clk         (clk),
        .rst         (rst),
        .ctrl_enable (ctrl_enable),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .cnt         (cnt),
        .bus_idle    (bus_idle)
    );

    assign hcnt_out = cnt;

endmodule

// File: tb/scl_hcnt_regblk_test.sv
module scl_hcnt_regblk_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [7:0]  BASE       = 8'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  psel = '0;
    logic        penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic        ctrl_enable = 1'b0, scl_in = 1'b1, sda_in = 1'b1;

    logic [31:0] prd_w, prd_h;
    logic [7:0]  prd_n;
    logic [15:0] hc_w, hc_n, hc_h;
    logic        idle_w, idle_n, idle_h;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_hcnt_regblk uut (
        .clk(clk), .rst(rst), .psel(psel[0]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd_w), .ctrl_enable(ctrl_enable),
        .scl_in(scl_in), .sda_in(sda_in), .hcnt_out(hc_w), .bus_idle(idle_w));

    scl_hcnt_regblk #(.DATA_W(8)) uut_n (
        .clk(clk), .rst(rst), .psel(psel[1]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata[7:0]), .prdata(prd_n), .ctrl_enable(ctrl_enable),
        .scl_in(scl_in), .sda_in(sda_in), .hcnt_out(hc_n), .bus_idle(idle_n));

    scl_hcnt_regblk #(.RESET_HCNT(16'd300), .HARD_CODED(1'b1)) uut_h (
        .clk(clk), .rst(rst), .psel(psel[2]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd_h), .ctrl_enable(ctrl_enable),
        .scl_in(scl_in), .sda_in(sda_in), .hcnt_out(hc_h), .bus_idle(idle_h));

    typedef struct {
        string       req;
        int          port;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int    n_chk = 0, n_fail = 0;
    event  chk_ev;

    function automatic logic [31:0] actual(input int p);
        case (p)
            0: return {16'h0, hc_w};
            1: return {31'h0, idle_w};
            2: return prd_w;
            3: return {16'h0, hc_n};
            4: return {24'h0, prd_n};
            5: return {31'h0, idle_n};
            6: return {16'h0, hc_h};
            7: return prd_h;
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] a;
                it = q.pop_front();
                a  = actual(it.port);
                n_chk++;
                if (a !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s port%0d actual=%h expected=%h", it.req, it.port, a, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input string r, input int p, input logic [31:0] e);
        q.push_back('{req: r, port: p, exp: e});
    endtask

    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    task automatic apb_wr(input int which, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = '0; psel[which] = 1'b1;
        paddr = a; pwdata = d; pwrite = 1'b1; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = '0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] a);
        paddr = a;
        #1;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    logic done = 1'b0;

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        edges(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        set_addr(BASE);
        expect_val("R1", 0, 32'd500);
        expect_val("R1", 1, 32'd0);
        expect_val("R1", 3, 32'd500);
        expect_val("R1", 6, 32'd300);
        flush();

        // R2 full write, reserved bits read zero
        apb_wr(0, BASE, 32'hABCD_1234);
        set_addr(BASE);
        expect_val("R2", 0, 32'h1234);
        expect_val("R2", 2, 32'h0000_1234);
        flush();

        // R10 other address ignored, reads zero
        apb_wr(0, BASE + 8'd4, 32'h0000_0055);
        set_addr(BASE + 8'd4);
        expect_val("R10", 0, 32'h1234);
        expect_val("R10", 2, 32'h0);
        flush();

        // R4 clamp
        apb_wr(0, BASE, 32'd3);
        expect_val("R4", 0, 32'd6); flush();
        apb_wr(0, BASE, 32'd0);
        expect_val("R4", 0, 32'd6); flush();
        apb_wr(0, BASE, 32'd7);
        expect_val("R4", 0, 32'd7); flush();

        // R3 write while enabled ignored
        ctrl_enable = 1'b1;
        apb_wr(0, BASE, 32'h0100);
        expect_val("R3", 0, 32'd7); flush();
        ctrl_enable = 1'b0;

        // R5 byte-ordered programming on the narrow bus
        apb_wr(1, BASE, 32'h34);
        expect_val("R5", 3, 32'd500); flush();
        apb_wr(1, BASE + 8'd1, 32'h12);
        set_addr(BASE);
        expect_val("R5", 3, 32'h1234);
        expect_val("R5", 4, 32'h34);
        flush();
        set_addr(BASE + 8'd1);
        expect_val("R5", 4, 32'h12); flush();
        apb_wr(1, BASE, 32'h02);
        apb_wr(1, BASE + 8'd1, 32'h00);
        expect_val("R5", 3, 32'd6); flush();
        // R3 low byte while enabled leaves the shadow alone
        ctrl_enable = 1'b1;
        apb_wr(1, BASE, 32'h99);
        ctrl_enable = 1'b0;
        apb_wr(1, BASE + 8'd1, 32'h01);
        expect_val("R3", 3, 32'h0102); flush();

        // R6 hard-coded variant
        apb_wr(2, BASE, 32'h0500);
        set_addr(BASE);
        expect_val("R6", 6, 32'd300);
        expect_val("R6", 7, 32'd300);
        flush();

        // R7/R9 idle detection: uut count 6 -> 16, uut_n count 258 -> 268
        apb_wr(0, BASE, 32'd6);
        scl_in = 1'b1; sda_in = 1'b1;
        ctrl_enable = 1'b1;
        edges(15);
        expect_val("R7", 1, 32'd0); flush();
        edges(1);
        expect_val("R7", 1, 32'd1);
        expect_val("R9", 5, 32'd0);
        flush();
        edges(5);
        expect_val("R8", 1, 32'd1); flush();
        edges(246);
        expect_val("R9", 5, 32'd0); flush();
        edges(1);
        expect_val("R9", 5, 32'd1); flush();

        // R8 clear on SCL low
        scl_in = 1'b0;
        edges(1);
        expect_val("R8", 1, 32'd0);
        expect_val("R8", 5, 32'd0);
        flush();
        scl_in = 1'b1;
        edges(16);
        expect_val("R7", 1, 32'd1); flush();
        // R8 clear on SDA low
        sda_in = 1'b0;
        edges(1);
        expect_val("R8", 1, 32'd0); flush();
        sda_in = 1'b1;
        edges(16);
        expect_val("R8", 1, 32'd1); flush();
        // R8 clear on disable
        ctrl_enable = 1'b0;
        edges(1);
        expect_val("R8", 1, 32'd0); flush();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule